// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block receives serial audio as a slave. The bit clock comes from outside and clocks the block directly. A shared word-select line and a group of serial data lines arrive with it, and the block turns each line's stream into parallel samples. The default build has two data lines. Each line carries a left and a right channel, so the default gives four logical channels.

Framing is chosen by a static format code. The codes select standard I2S, left-justified or right-justified framing, or a raw capture mode. In raw mode the block packs the data and word-select levels from every clock into words, with no framing at all. The sample width (1 to 32 bits) and the bit order (MSB-first or LSB-first) are also static inputs. The surrounding logic holds the block in reset while it changes any configuration input.

Each line has its own registered output word, valid pulse and channel flag. All lines share one framing state, so their strobes always occur in the same cycle.

Top module: `audio_serial_rx`

## Requirements
- R1: While `rst` is high, and on the first edge after it is released, every `samp_valid` bit is low. Every `samp_data` word reads zero until the first sample is produced.
- R2: `cfg_fmt` selects the framing: 0 is standard I2S, 1 is left-justified, 2 is right-justified and 3 is raw capture.
- R3: In I2S framing, the first bit of a slot is sampled on the edge after the edge where the word-select change is first seen. Bits arrive MSB-first by default. The slot belongs to the new word-select level (0 means left, 1 means right). The sample is output on the edge that captures the slot's W-th bit.
- R4: In left-justified framing, the first bit of a slot is sampled on the same edge where the word-select change is first seen. The sample is output on the edge that captures the slot's W-th bit, with the flag set from that word-select level.
- R5: In right-justified framing, the sample is the last W bits before a word-select change. It is output on the edge where the change is first seen, flagged with the word-select level of the slot that just ended.
- R6: The sample width W comes from `cfg_width`. A value of 0 or any value above 32 means 32. Samples are right-aligned in the 32-bit word, and bits at position W and above read zero.
- R7: When `cfg_lsb_first` is 1, the earliest bit of the sample lands at bit 0. When it is 0, the earliest bit is the MSB, at bit W-1.
- R8: Each data line is deserialised separately under the shared framing. Line k's word occupies `samp_data[32k+31:32k]`, and all lines signal valid on the same cycles.
- R9: In raw mode, each edge adds the pair {ws, sd} to the current line's word. Edge n after reset goes to bits [2(n mod 16)+1 : 2(n mod 16)]. A word is output on every 16th edge, with the channel flag 0.
- R10: A slot cut short by reset produces no sample. A framed slot with fewer than W bits also produces no sample. In I2S and left-justified framing, bits after the W-th bit of a slot are ignored.
- R11: Each valid pulse lasts one cycle per completed sample. No valid pulse appears on a cycle without a completed sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock from the external master; data and word select are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ws | input | 1 | Word select (0 left, 1 right) |
| sd | input | NUM_LINES | Serial data, one bit per line |
| cfg_fmt | input | 2 | Format code (0 I2S, 1 left-justified, 2 right-justified, 3 raw) |
| cfg_width | input | WW (6) | Sample width in bits; 0 or above 32 means 32 |
| cfg_lsb_first | input | 1 | 1 selects LSB-first bit order |
| samp_data | output | NUM_LINES*32 | Right-aligned sample word per line |
| samp_valid | output | NUM_LINES | One-cycle sample strobe per line |
| samp_right | output | NUM_LINES | Channel of the sample (1 right, 0 left; 0 in raw mode) |

## Verification
All results appear one register stage after the edge that completes them.

| Framing | Edge on which the output word updates |
|---|---|
| Left-justified | Edge that captures the W-th bit after the word-select change |
| I2S | The same, but counting starts one edge after the change |
| Right-justified | Edge on which the change itself is sampled |
| Raw | Every sixteenth edge |

The bench works per edge:
- It drives inputs on the falling edge.
- On the rising edge it records the values in history queues and works out from them what that edge must produce.
- It compares at the next falling edge, so every valid, data and flag check lands exactly one edge after its last contributing input.

// File: rtl/sai_rx_pkg.sv
package sai_rx_pkg;
  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_RAW = 2'd3
  } fmt_e;
endpackage

// File: rtl/sai_frame_ctl.sv
// Shared framing state: word-select history, slot bit index, channel and
// raw capture position. Drives emit decisions for every data line.
module sai_frame_ctl
  import sai_rx_pkg::*;
#(
  parameter int DW   = 32,
  parameter int WW   = $clog2(DW + 1),
  parameter int CNTW = WW + 1,
  parameter int RCW  = $clog2(DW / 2)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ws,
  input  fmt_e            fmt,
  input  logic [WW-1:0]   width,
  output logic            bound,
  output logic [CNTW-1:0] idx,
  output logic            emit_fr,
  output logic            emit_rj,
  output logic            emit_raw,
  output logic            slot_right,
  output logic [RCW-1:0]  raw_pos
);
  localparam logic [CNTW-1:0] CMAX  = '1;
  localparam logic [RCW-1:0]  RLAST = '1;

  logic            ws_q, ws_qq, locked_q, ch_q;
  logic [1:0]      seen_q;
  logic [CNTW-1:0] cnt_q;
  logic [CNTW-1:0] wm1;
  logic            new_ch, active;

  always_comb begin
    wm1    = CNTW'(width) - CNTW'(1);
    if (fmt == FMT_I2S) begin
      bound  = (seen_q == 2'd2) && (ws_q != ws_qq);
      new_ch = ws_q;
    end else begin
      bound  = (seen_q != 2'd0) && (ws != ws_q);
      new_ch = ws;
    end
    if (bound)             idx = '0;
    else if (cnt_q == CMAX) idx = CMAX;
    else                   idx = cnt_q + CNTW'(1);
    active     = bound | locked_q;
    emit_fr    = (fmt == FMT_I2S || fmt == FMT_LJ) && active && (idx == wm1);
    emit_rj    = (fmt == FMT_RJ) && bound && locked_q && (cnt_q >= wm1);
    emit_raw   = (fmt == FMT_RAW) && (raw_pos == RLAST);
    if (fmt == FMT_RJ) slot_right = ws_q;
    else               slot_right = bound ? new_ch : ch_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_q     <= 1'b0;
      ws_qq    <= 1'b0;
      seen_q   <= 2'd0;
      locked_q <= 1'b0;
      ch_q     <= 1'b0;
      cnt_q    <= '0;
      raw_pos  <= '0;
    end else begin
      ws_q    <= ws;
      ws_qq   <= ws_q;
      raw_pos <= raw_pos + RCW'(1);
      if (seen_q != 2'd2) seen_q <= seen_q + 2'd1;
      if (bound) begin
        locked_q <= 1'b1;
        ch_q     <= new_ch;
      end
      if (active) cnt_q <= idx;
    end
  end
endmodule

// File: rtl/sai_line_shift.sv
// Per-line deserialiser with a registered output word, strobe and flag.
module sai_line_shift
  import sai_rx_pkg::*;
#(
  parameter int DW   = 32,
  parameter int WW   = $clog2(DW + 1),
  parameter int CNTW = WW + 1,
  parameter int RCW  = $clog2(DW / 2)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sd,
  input  logic            ws,
  input  fmt_e            fmt,
  input  logic [WW-1:0]   width,
  input  logic            lsb_first,
  input  logic            bound,
  input  logic [CNTW-1:0] idx,
  input  logic            emit_fr,
  input  logic            emit_rj,
  input  logic            emit_raw,
  input  logic            slot_right,
  input  logic [RCW-1:0]  raw_pos,
  output logic [DW-1:0]   data_o,
  output logic            valid_o,
  output logic            right_o
);
  logic [DW-1:0] acc, acc_n, base, mask, out_val, bit_w, pair_w;
  logic          emit;

  always_comb begin
    bit_w  = {{(DW-1){1'b0}}, sd};
    pair_w = {{(DW-2){1'b0}}, ws, sd};
    mask   = (width >= WW'(DW)) ? '1 : ((DW'(1) << width) - DW'(1));
    base   = acc;
    case (fmt)
      FMT_RAW: begin
        base  = (raw_pos == '0) ? '0 : acc;
        acc_n = base | (pair_w << (2 * raw_pos));
      end
      FMT_RJ: begin
        if (lsb_first) acc_n = (acc >> 1) | (bit_w << (width - WW'(1)));
        else           acc_n = (acc << 1) | bit_w;
      end
      default: begin
        base = bound ? '0 : acc;
        if (lsb_first) acc_n = (idx < CNTW'(DW)) ? (base | (bit_w << idx)) : base;
        else           acc_n = (base << 1) | bit_w;
      end
    endcase
    case (fmt)
      FMT_RAW: out_val = acc_n;
      FMT_RJ:  out_val = acc & mask;
      default: out_val = acc_n & mask;
    endcase
    emit = emit_fr | emit_rj | emit_raw;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
      right_o <= 1'b0;
    end else begin
      acc     <= acc_n;
      valid_o <= emit;
      if (emit) begin
        data_o  <= out_val;
        right_o <= (fmt == FMT_RAW) ? 1'b0 : slot_right;
      end
    end
  end
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import sai_rx_pkg::*;
#(
  parameter int NUM_LINES = 2,
  parameter int DW        = 32,
  parameter int WW        = $clog2(DW + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ws,
  input  logic [NUM_LINES-1:0]    sd,
  input  logic [1:0]              cfg_fmt,
  input  logic [WW-1:0]           cfg_width,
  input  logic                    cfg_lsb_first,
  output logic [NUM_LINES*DW-1:0] samp_data,
  output logic [NUM_LINES-1:0]    samp_valid,
  output logic [NUM_LINES-1:0]    samp_right
);
  localparam int CNTW = WW + 1;
  localparam int RCW  = $clog2(DW / 2);

  fmt_e            fmt;
  logic [WW-1:0]   w_eff;
  logic            bound, emit_fr, emit_rj, emit_raw, slot_right;
  logic [CNTW-1:0] idx;
  logic [RCW-1:0]  raw_pos;

  assign fmt   = fmt_e'(cfg_fmt);
  assign w_eff = (cfg_width == '0 || cfg_width > WW'(DW)) ? WW'(DW) : cfg_width;

  sai_frame_ctl #(.DW(DW), .WW(WW), .CNTW(CNTW), .RCW(RCW)) u_frame (
    .clk(clk), .rst(rst), .ws(ws), .fmt(fmt), .width(w_eff),
    .bound(bound), .idx(idx), .emit_fr(emit_fr), .emit_rj(emit_rj),
    .emit_raw(emit_raw), .slot_right(slot_right), .raw_pos(raw_pos)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    sai_line_shift #(.DW(DW), .WW(WW), .CNTW(CNTW), .RCW(RCW)) u_line (
      .clk(clk), .rst(rst), .sd(sd[g]), .ws(ws), .fmt(fmt), .width(w_eff),
      .lsb_first(cfg_lsb_first), .bound(bound), .idx(idx),
      .emit_fr(emit_fr), .emit_rj(emit_rj), .emit_raw(emit_raw),
      .slot_right(slot_right), .raw_pos(raw_pos),
      .data_o(samp_data[g*DW +: DW]), .valid_o(samp_valid[g]),
      .right_o(samp_right[g])
    );
  end
endmodule

// File: rtl/audio_serial_rx_chk.sv
module audio_serial_rx_chk #(
  parameter int NUM_LINES = 2,
  parameter int DW        = 32,
  parameter int WW        = $clog2(DW + 1)
) (
  input logic                    clk,
  input logic                    rst,
  input logic [1:0]              cfg_fmt,
  input logic [WW-1:0]           cfg_width,
  input logic [NUM_LINES*DW-1:0] samp_data,
  input logic [NUM_LINES-1:0]    samp_valid,
  input logic [NUM_LINES-1:0]    samp_right
);
  logic [DW-1:0] lim;
  always_comb begin
    if (cfg_width == '0 || cfg_width >= WW'(DW)) lim = '1;
    else lim = (DW'(1) << cfg_width) - DW'(1);
  end

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> samp_valid == '0);

  assert_lines_together_R8: assert property (@(posedge clk) disable iff (rst)
    ($countones(samp_valid) == 0) || ($countones(samp_valid) == NUM_LINES));

  assert_raw_spacing_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_fmt == 2'd3 && samp_valid[0]) |=> !samp_valid[0]);

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_chk
    assert_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
      (samp_valid[g] && cfg_fmt != 2'd3) |-> ((samp_data[g*DW +: DW] & ~lim) == '0));
    assert_raw_flag_R9: assert property (@(posedge clk) disable iff (rst)
      (samp_valid[g] && cfg_fmt == 2'd3) |-> !samp_right[g]);
  end
endmodule

bind audio_serial_rx audio_serial_rx_chk #(.NUM_LINES(NUM_LINES), .DW(DW), .WW(WW)) u_chk (
  .clk(clk), .rst(rst), .cfg_fmt(cfg_fmt), .cfg_width(cfg_width),
  .samp_data(samp_data), .samp_valid(samp_valid), .samp_right(samp_right)
);

// File: tb/audio_serial_rx_tb_top.sv
module audio_serial_rx_tb_top;
  localparam int NL = 2;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ws = 1'b0;
  logic [NL-1:0] sd = '0;
  logic [1:0]    cfg_fmt = 2'd0;
  logic [5:0]    cfg_width = 6'd24;
  logic          cfg_lsb_first = 1'b0;
  logic [NL*DW-1:0] samp_data;
  logic [NL-1:0] samp_valid, samp_right;

  audio_serial_rx #(.NUM_LINES(NL), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .ws(ws), .sd(sd), .cfg_fmt(cfg_fmt),
    .cfg_width(cfg_width), .cfg_lsb_first(cfg_lsb_first),
    .samp_data(samp_data), .samp_valid(samp_valid), .samp_right(samp_right)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  bit            ws_h[$];
  logic [NL-1:0] sd_h[$];
  int            last_b;
  int            w_eff;
  bit            ev;
  bit            er;
  logic [DW-1:0] ed [NL];

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic logic [DW-1:0] build(int st, int ln);
    logic [DW-1:0] v = '0;
    for (int j = 0; j < w_eff; j++)
      if (sd_h[st + j][ln]) v[cfg_lsb_first ? j : (w_eff - 1 - j)] = 1'b1;
    return v;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // reference model for the edge just recorded
  task automatic model();
    int  t = ws_h.size() - 1;
    bit  b;
    ev = 1'b0; er = 1'b0;
    if (cfg_fmt == 2'd3) begin
      if (t % 16 == 15) begin
        ev = 1'b1;
        for (int l = 0; l < NL; l++) begin
          ed[l] = '0;
          for (int j = 0; j < 16; j++) begin
            ed[l][2*j]   = sd_h[t - 15 + j][l];
            ed[l][2*j+1] = ws_h[t - 15 + j];
          end
        end
      end
      return;
    end
    if (cfg_fmt == 2'd0) b = (t >= 2) && (ws_h[t-1] != ws_h[t-2]);
    else                 b = (t >= 1) && (ws_h[t] != ws_h[t-1]);
    if (cfg_fmt == 2'd2) begin
      if (b && last_b >= 0 && (t - last_b) >= w_eff) begin
        ev = 1'b1; er = ws_h[t-1];
        for (int l = 0; l < NL; l++) ed[l] = build(t - w_eff, l);
      end
      if (b) last_b = t;
    end else begin
      if (b) last_b = t;
      if (last_b >= 0 && (t - last_b) == w_eff - 1) begin
        ev = 1'b1;
        er = (cfg_fmt == 2'd0) ? ws_h[last_b-1] : ws_h[last_b];
        for (int l = 0; l < NL; l++) ed[l] = build(last_b, l);
      end
    end
  endtask

  // called at a falling edge: drive, record at rise, compare at next fall
  task automatic step(bit w, logic [NL-1:0] d, string tag);
    ws = w; sd = d;
    @(posedge clk);
    ws_h.push_back(w); sd_h.push_back(d);
    model();
    @(negedge clk);
    check(samp_valid == {NL{ev}}, "R11", "valid", DW'(samp_valid), DW'({NL{ev}}));
    if (ev)
      for (int l = 0; l < NL; l++) begin
        check(samp_data[l*DW +: DW] == ed[l], tag, $sformatf("line %0d data", l),
              samp_data[l*DW +: DW], ed[l]);
        check(samp_right[l] == er, tag, $sformatf("line %0d channel", l),
              DW'(samp_right[l]), DW'(er));
      end
  endtask

  task automatic run_case(int fmt, int wcfg, bit lsb, int len_a, int len_b, int halves, string tag);
    bit w;
    @(negedge clk);
    rst = 1'b1; cfg_fmt = 2'(fmt); cfg_width = 6'(wcfg); cfg_lsb_first = lsb;
    ws = 1'b0; sd = '1;
    repeat (3) @(negedge clk);
    // R1: outputs idle in reset
    check(samp_valid == '0, "R1", "valid in reset", DW'(samp_valid), '0);
    check(samp_data == '0, "R1", "data in reset", samp_data[DW-1:0], '0);
    rst = 1'b0;
    ws_h.delete(); sd_h.delete(); last_b = -1;
    w_eff = (wcfg == 0 || wcfg > DW) ? DW : wcfg;
    for (int i = 0; i < 5; i++) step(1'b0, NL'($urandom), tag);   // partial lead slot
    w = 1'b1;
    for (int h = 0; h < halves; h++) begin
      for (int i = 0; i < ((h % 2) ? len_b : len_a); i++) step(w, NL'($urandom), tag);
      w = ~w;
    end
    for (int i = 0; i < 3; i++) step(w, NL'($urandom), tag);
  endtask

  initial begin
    run_case(0, 24, 1'b0, 32, 32, 8, "R3");
    run_case(0, 16, 1'b0, 16, 16, 8, "R3");
    run_case(1, 24, 1'b0, 32, 32, 8, "R2");
    run_case(1, 20, 1'b0, 32, 28, 8, "R4");
    run_case(1, 1,  1'b0, 8,  8,  8, "R6");
    run_case(1, 0,  1'b0, 32, 32, 6, "R6");
    run_case(1, 12, 1'b1, 16, 16, 8, "R7");
    run_case(0, 32, 1'b1, 32, 32, 6, "R7");
    run_case(2, 16, 1'b0, 32, 32, 8, "R5");
    run_case(2, 10, 1'b1, 24, 6,  8, "R5");
    run_case(1, 16, 1'b0, 24, 8,  8, "R10");
    run_case(0, 24, 1'b0, 25, 31, 8, "R8");
    run_case(3, 16, 1'b0, 20, 20, 6, "R9");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule